// File: doc/BRIEF.md
# Programmable Video Line Delay

This block holds back every incoming pixel by exactly one video line. A line store is addressed by a single pointer. On each access the word already at that address is read out and the new pixel is written into the same word, so the pixel that leaves the block is the one that arrived at the same position on the previous line. The pointer starts again from zero at every line start. Because of this, a line that is one pixel longer or shorter than the one before it cannot shift the picture from line to line.

The horizontal sync input may change with no fixed relation to the pixel clock. It passes through a two-flop synchronizer, and a falling edge of the synchronized sync starts a line. The line length is set in one of three ways:
- In sync-timed mode, the line lasts as long as the sync stays low.
- In fixed-length mode, the line takes a programmed count and ignores the sync rising.
- In streaming mode, the pointer wraps back to zero at the programmed count with no idle cycle and keeps going until the sync rises. This mode suits frame-store or line-scan sources.

The block also outputs a copy of the sync that is delayed to match the pixel pipeline. Downstream logic can use it to gate writes while it is low.

Top module: `video_line_delay`

## Requirements
- R1: Each pixel output after an access equals the pixel written to the same pointer position during the previous line, read before the new pixel overwrites it.
- R2: `syncOut` is `syncIn` delayed by exactly four clock edges. The first access of a line samples `pixIn` on the fourth rising edge after `syncIn` is sampled low, and its result appears on `pixOut` after that edge, when `syncOut` first reads low.
- R3: In sync-timed mode (`modeSel` 0, and also 3), while the synchronized sync is high, nothing is written and the pointer is held at zero. A line whose sync stays low for L clocks stores L-1 pixels at positions 0 to L-2 and leaves every higher position unchanged.
- R4: In sync-timed mode, once position 2^AW-1 has been written, no further write happens in that line. The pointer does not wrap, so position 0 keeps the line's first pixel.
- R5: In fixed-length mode (`modeSel` 1), a line stores exactly V+1 pixels, where V is the effective programmed value. This holds whether the sync rises before or after that count is reached.
- R6: Bit 0 of the programmed value is always treated as 1, so every programmed line has an even length. A stored value of 4 gives 6 pixels.
- R7: A length value written to the configuration registers is captured only at a line start: a sync falling edge, or a streaming-mode wrap. The line already in progress keeps its old length.
- R8: In streaming mode (`modeSel` 2), the access after position V is at position 0 on the very next clock. While the sync stays low, every output pixel equals the input pixel taken exactly V+1 accesses earlier.
- R9: On any clock with no access, `pixOut` keeps its previous value.
- R10: While reset is asserted and just after it, `pixOut` is 0 and `syncOut` is 1.
- R11: A configuration write with `cfgAddr` 0 loads the low 8 bits of the length value. A write with `cfgAddr` 1 loads bits AW-1 to 8 from the low bits of `cfgData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low asynchronous reset |
| syncIn | input | 1 | Horizontal sync or update-period signal, may be asynchronous; low marks the active period |
| modeSel | input | 2 | 0 sync-timed, 1 fixed-length, 2 streaming, 3 treated as sync-timed |
| cfgWr | input | 1 | Configuration write strobe |
| cfgAddr | input | 1 | 0 selects the low length byte, 1 the high length bits |
| cfgData | input | 8 | Configuration write data |
| pixIn | input | DW | Incoming pixel |
| pixOut | output | DW | Pixel delayed by one line |
| syncOut | output | 1 | Sync delayed to match the pixel path |

## Verification
Sync-timed lines of different lengths show whether the store holds exactly L-1 pixels. A shorter line that follows a longer one leaves the tail untouched, and the next line reads that tail back. Lines longer than the store tell a capped pointer from a wrapping one, because the pixels past the end carry a marker value that must never show up at position 0. Fixed-length lines are driven with a sync that rises early. A length is rewritten in the middle of a line and a value that needs the high byte is loaded; these separate the forced-even rule, the capture at line start and the byte map from one another. A long streaming line with a short count shows whether the wrap loses a cycle: any idle cycle would break the fixed four-access delay.

// File: rtl/ld_pkg.sv
package ld_pkg;

  typedef enum logic [1:0] {
    MODE_SYNC = 2'd0,
    MODE_PROG = 2'd1,
    MODE_CONT = 2'd2
  } lineMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } ldStrb_t;

  localparam int CFG_W       = 8;
  localparam int SYNC_STAGES = 2;  // synchronizer flops
  localparam int ALIGN_STAGES = 2; // edge detect + read register

endpackage

// File: rtl/ld_ctrl.sv
module ld_ctrl
  import ld_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncIn,
  input  logic [1:0]        modeSel,
  input  logic              cfgWr,
  input  logic              cfgAddr,
  input  logic [CFG_W-1:0]  cfgData,
  output ldStrb_t           strb,
  output logic [AW-1:0]     ptr,
  output logic              syncOut
);

  localparam int HIW = AW - CFG_W;
  localparam logic [AW-1:0] MAXA = '1;

  lineMode_e modeNow;
  assign modeNow = lineMode_e'(modeSel);

  // sync capture and alignment pipe
  logic [SYNC_STAGES-1:0]  syncSh;
  logic [ALIGN_STAGES-1:0] alignSh;
  logic syncS2;
  logic fallDet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncSh  <= '1;
      alignSh <= '1;
    end else begin
      syncSh  <= {syncSh[SYNC_STAGES-2:0], syncIn};
      alignSh <= {alignSh[ALIGN_STAGES-2:0], syncSh[SYNC_STAGES-1]};
    end
  end

  assign syncS2  = syncSh[SYNC_STAGES-1];
  assign fallDet = alignSh[0] & ~syncS2;
  assign syncOut = alignSh[ALIGN_STAGES-1];

  // length registers
  logic [AW-1:0] lenShadow;
  logic [AW-1:0] lenEff;
  logic [AW-1:0] lenLive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenShadow <= MAXA;
    end else if (cfgWr) begin
      if (!cfgAddr) lenShadow[CFG_W-1:0] <= cfgData;
      else          lenShadow[AW-1:CFG_W] <= cfgData[HIW-1:0];
    end
  end

  generate
    if (HIW < CFG_W) begin : g_unusedCfg
      logic unusedHi;
      assign unusedHi = ^cfgData[CFG_W-1:HIW];
    end
  endgenerate

  assign lenEff = lenShadow | AW'(1);

  // address counter
  logic active;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      ptr     <= '0;
      lenLive <= MAXA;
    end else if (fallDet) begin
      active  <= 1'b1;
      ptr     <= '0;
      lenLive <= lenEff;
    end else if (active) begin
      if (modeNow == MODE_PROG) begin
        if (ptr == lenLive) begin
          active <= 1'b0;
          ptr    <= '0;
        end else begin
          ptr <= ptr + 1'b1;
        end
      end else if (syncS2) begin
        active <= 1'b0;
        ptr    <= '0;
      end else if (modeNow == MODE_CONT) begin
        if (ptr == lenLive) begin
          ptr     <= '0;
          lenLive <= lenEff;
        end else begin
          ptr <= ptr + 1'b1;
        end
      end else if (ptr == MAXA) begin
        active <= 1'b0;
      end else begin
        ptr <= ptr + 1'b1;
      end
    end else if (syncS2) begin
      ptr <= '0;
    end
  end

  always_comb begin
    strb.wrEn = active && !(syncS2 && modeNow != MODE_PROG);
    strb.rdEn = strb.wrEn;
  end

  // assertion-only warm-up counter
  logic [2:0] warmCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) warmCnt <= '0;
    else if (warmCnt != 3'd4) warmCnt <= warmCnt + 3'd1;
  end

  // R2
  sync_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warmCnt == 3'd4) |-> (syncOut == $past(syncIn, 4)));

  // R3
  sync_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (syncS2 && modeNow != MODE_PROG) |=> (ptr == '0));

  // R4
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && ptr == MAXA && modeNow != MODE_PROG && modeNow != MODE_CONT && !fallDet)
    |=> !strb.wrEn);

  // R5
  prog_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && modeNow == MODE_PROG && ptr == lenLive && !fallDet) |=> !strb.wrEn);

  // R8
  cont_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && modeNow == MODE_CONT && ptr == lenLive && !fallDet)
    |=> (ptr == '0 && active));

endmodule

// File: rtl/ld_datapath.sv
module ld_datapath
  import ld_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  ldStrb_t       strb,
  input  logic [AW-1:0] ptr,
  input  logic [DW-1:0] pixIn,
  output logic [DW-1:0] pixOut
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] lineMem [DEPTH];

  always_ff @(posedge clk) begin
    if (strb.wrEn) lineMem[ptr] <= pixIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          pixOut <= '0;
    else if (strb.rdEn) pixOut <= lineMem[ptr];
  end

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdEn |=> $stable(pixOut));

endmodule

// File: rtl/video_line_delay.sv
module video_line_delay
  import ld_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          syncIn,
  input  logic [1:0]    modeSel,
  input  logic          cfgWr,
  input  logic          cfgAddr,
  input  logic [7:0]    cfgData,
  input  logic [DW-1:0] pixIn,
  output logic [DW-1:0] pixOut,
  output logic          syncOut
);

  ldStrb_t       strb;
  logic [AW-1:0] ptr;

  ld_ctrl #(.AW(AW)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .syncIn  (syncIn),
    .modeSel (modeSel),
    .cfgWr   (cfgWr),
    .cfgAddr (cfgAddr),
    .cfgData (cfgData),
    .strb    (strb),
    .ptr     (ptr),
    .syncOut (syncOut)
  );

  ld_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .ptr    (ptr),
    .pixIn  (pixIn),
    .pixOut (pixOut)
  );

endmodule

// File: tb/video_line_delay_bench.sv
module video_line_delay_bench;

  logic       clk = 1'b0;
  logic       rstN;
  logic       syncIn;
  logic [1:0] modeSel;
  logic       cfgWr;
  logic       cfgAddr;
  logic [7:0] cfgData;
  logic [7:0] pixIn;
  logic [7:0] pixOut;
  logic       syncOut;

  int chkCnt = 0;
  int failCnt = 0;
  int lineNo = 0;
  logic [7:0] obsPix;
  logic       obsSync;
  logic [7:0] model [0:1023];
  bit         modelOk [0:1023];
  logic [7:0] pixAt [0:2047];

  always #2 clk = ~clk;

  video_line_delay u_video_line_delay (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .modeSel(modeSel),
    .cfgWr(cfgWr), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .pixIn(pixIn), .pixOut(pixOut), .syncOut(syncOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    chkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pixFor(input int ln, input int s);
    if (s >= 1027) return 8'hEE;
    return 8'((s * 3 + ln * 17) & 127);
  endfunction

  // sample outputs, then drive inputs, at the falling edge
  task automatic tick(input logic sv, input logic [7:0] pv,
                      input logic wr, input logic a, input logic [7:0] d);
    @(negedge clk);
    obsPix  = pixOut;
    obsSync = syncOut;
    syncIn  = sv;
    pixIn   = pv;
    cfgWr   = wr;
    cfgAddr = a;
    cfgData = d;
  endtask

  task automatic cfgSet(input logic [7:0] lo, input logic [7:0] hi);
    tick(1'b1, 8'h00, 1'b1, 1'b0, lo);
    tick(1'b1, 8'h00, 1'b1, 1'b1, hi);
    tick(1'b1, 8'h00, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic runLine(input int lowLen, input int total, input int nAcc,
                         input int wrStep, input logic [7:0] wrLo, input logic [7:0] wrHi,
                         input string tag, input string holdTag);
    for (int s = 0; s < total; s++) begin
      logic [7:0] p;
      logic wr;
      logic a;
      logic [7:0] d;
      int j;
      p = pixFor(lineNo, s);
      pixAt[s] = p;
      wr = 1'b0; a = 1'b0; d = 8'h00;
      if (s == wrStep) begin wr = 1'b1; a = 1'b0; d = wrLo; end
      if (wrStep >= 0 && s == wrStep + 1) begin wr = 1'b1; a = 1'b1; d = wrHi; end
      tick((s < lowLen) ? 1'b0 : 1'b1, p, wr, a, d);
      // R2: sync copy falls with the first result
      if (s == 3) check(obsSync == 1'b1, "R2", int'(obsSync), 1);
      if (s == 4) check(obsSync == 1'b0, "R2", int'(obsSync), 0);
      j = s - 4;
      if (j >= 0 && j < nAcc && modelOk[j])
        check(obsPix == model[j], tag, int'(obsPix), int'(model[j]));
      if (j == nAcc && modelOk[nAcc-1])
        check(obsPix == model[nAcc-1], holdTag, int'(obsPix), int'(model[nAcc-1]));
    end
    for (int j = 0; j < nAcc; j++) begin
      model[j] = pixAt[3 + j];
      modelOk[j] = 1'b1;
    end
    lineNo++;
  endtask

  task automatic runCont(input int lowLen, input int total, input int span);
    for (int s = 0; s < total; s++) begin
      logic [7:0] p;
      int j;
      p = pixFor(lineNo, s);
      pixAt[s] = p;
      tick((s < lowLen) ? 1'b0 : 1'b1, p, 1'b0, 1'b0, 8'h00);
      j = s - 4;
      // R8: fixed delay of span accesses across the wrap
      if (j >= span && j <= lowLen - 2)
        check(obsPix == pixAt[s - 1 - span], "R8", int'(obsPix), int'(pixAt[s - 1 - span]));
    end
    lineNo++;
  endtask

  task automatic testReset();
    rstN = 1'b0; syncIn = 1'b1; modeSel = 2'd0; cfgWr = 1'b0;
    cfgAddr = 1'b0; cfgData = 8'h00; pixIn = 8'h00;
    for (int i = 0; i < 4; i++) @(negedge clk);
    check(pixOut == 8'h00, "R10", int'(pixOut), 0);
    check(syncOut == 1'b1, "R10", int'(syncOut), 1);
    rstN = 1'b1;
    tick(1'b1, 8'h00, 1'b0, 1'b0, 8'h00);
    tick(1'b1, 8'h00, 1'b0, 1'b0, 8'h00);
    check(obsPix == 8'h00, "R10", int'(obsPix), 0);
    check(obsSync == 1'b1, "R10", int'(obsSync), 1);
  endtask

  task automatic testSyncLines();
    for (int j = 0; j < 1024; j++) modelOk[j] = 1'b0;
    runLine(40, 44, 39, -1, 8'h00, 8'h00, "R1", "R9");
    runLine(40, 44, 39, -1, 8'h00, 8'h00, "R1", "R9");
    // shorter line: 19 stored, then held output
    runLine(20, 24, 19, -1, 8'h00, 8'h00, "R3", "R9");
  endtask

  task automatic testLongLines();
    // R4: lines longer than the store, pixels past the end are 8'hEE
    runLine(1030, 1034, 1024, -1, 8'h00, 8'h00, "R3", "R4");
    runLine(1030, 1034, 1024, -1, 8'h00, 8'h00, "R4", "R4");
  endtask

  task automatic testProg();
    modeSel = 2'd1;
    cfgSet(8'd4, 8'd0);
    // R6: value 4 gives 6 pixels; R5: sync rises after 3 clocks; R7: rewrite mid-line
    runLine(3, 14, 6, 5, 8'd9, 8'd0, "R5", "R6");
    runLine(3, 18, 10, -1, 8'h00, 8'h00, "R7", "R7");
    // R11: high byte used, value 0x101 gives 258 pixels
    cfgSet(8'h01, 8'h01);
    runLine(3, 270, 258, -1, 8'h00, 8'h00, "R11", "R11");
  endtask

  task automatic testCont();
    modeSel = 2'd2;
    cfgSet(8'd3, 8'd0);
    runCont(24, 28, 4);
  endtask

  initial begin
    testReset();
    testSyncLines();
    testLongLines();
    testProg();
    testCont();
    $display("%0d/%0d checks passed", chkCnt - failCnt, chkCnt);
    $finish;
  end

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    chkCnt++;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", chkCnt - failCnt, chkCnt);
    $finish;
  end

endmodule